// File: doc/BRIEF.md
# Eight-Lamp Pattern Sequencer

This block drives a row of eight lamps through four fixed light shows, one after the other, and repeats them without end. A lamp output of 1 means the lamp is lit and 0 means it is dark. Bit 7 is the leftmost lamp and bit 0 is the rightmost. The shows are a single light running right to left and back, followed by all dark and then all lit. Next come one light at each end moving to the centre and back out, then a pair of lights at each end doing the same. The last show is three lights at each end, the left half, the right half, and finally every other lamp.

The block runs from a 500 Hz clock. A divider turns that clock into one step tick per displayed frame. A 2-bit select input sets the frame time to 1, 2, 3 or 4 seconds. The divider reads the select input only when a frame ends, so a frame in progress always runs its full length. After the last frame of a show, the next show starts on its own.

Top module: `lamp_sequencer`

## Requirements
- R1: While the active-low synchronous reset is low, and on the first cycle after it, the lamps show 8'h01. After reset, the first frame lasts a full frame time counted from the cycle reset was released.
- R2: Each frame lasts exactly (sel+1)*500 clock cycles, where sel is the 2-bit select value (0..3) in force for that frame.
- R3: A change of the select input during a frame does not change that frame's length. The new value sets the length of the frame that starts at the next boundary.
- R4: Show 1 is 18 frames long: 01,02,04,08,10,20,40,80 (moving left), then 80,40,20,10,08,04,02,01 (moving right), then 00, then FF. The values are hex, with bit 7 leftmost. During the first 16 frames exactly one lamp is lit.
- R5: Show 2 is 7 frames long: 81,42,24,18,24,42,81. It is mirror-symmetric.
- R6: Show 3 is 5 frames long: C3,66,3C,66,C3. It is mirror-symmetric.
- R7: Show 4 is 4 frames long: E7,F0,0F,55.
- R8: The shows play in the order 1,2,3,4. After the last frame of show 4, the sequencer returns to the first frame of show 1, so the full cycle is 34 frames long.
- R9: The lamp vector changes only at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 500 Hz system clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_sel_i | input | 2 | Frame time select: 0..3 gives 1..4 seconds |
| lamps_o | output | 8 | Lamp states, 1 means lit, bit 7 is the leftmost lamp |

## Verification
The full 34-frame cycle plus the wrap-around frame is walked at the shortest frame time against a table of expected lamp values. This separates the four shows and catches any wrong order, wrong length or missing repeated frame, such as the doubled 80 and 01 at the turn of show 1. Frame length is probed at every select value one cycle before and exactly at the boundary, which exposes off-by-one errors in the divider. Changing the select value in the middle of a frame, in both directions, shows whether the new value is applied early or late. A reset in the middle of a show checks that both the divider and the show position restart.

// File: rtl/lamp_seq_pkg.sv
// Shared constants, types and frame-value functions for the lamp sequencer.
// Assumes a fixed row of eight lamps, with bit 7 as the leftmost lamp.
package lamp_seq_pkg;

    localparam int LAMPS        = 8;
    localparam int NUM_PATTERNS = 4;
    localparam int PAT_W        = $clog2(NUM_PATTERNS);
    localparam int MAX_STEPS    = 2 * LAMPS + 2;
    localparam int STEP_W       = $clog2(MAX_STEPS + 1);

    typedef logic [LAMPS-1:0]  lamp_vec_t;
    typedef logic [PAT_W-1:0]  pat_idx_t;
    typedef logic [STEP_W-1:0] step_idx_t;

    // Number of frames in each show.
    function automatic step_idx_t pattern_len(input int p);
        case (p)
            0:       return step_idx_t'(2 * LAMPS + 2);
            1:       return step_idx_t'(LAMPS - 1);
            2:       return step_idx_t'(LAMPS - 3);
            default: return step_idx_t'(4);
        endcase
    endfunction

    // Groups of width w lit at offset k from both ends.
    function automatic lamp_vec_t mirror_group(input int k, input int w);
        lamp_vec_t v;
        v = '0;
        for (int i = 0; i < w; i++) begin
            v[k + i]             = 1'b1;
            v[LAMPS - 1 - k - i] = 1'b1;
        end
        return v;
    endfunction

    // Show 1: a single lamp runs left, then right, then all off, then all on.
    function automatic lamp_vec_t sweep_frame(input int s);
        if (s < LAMPS)          return lamp_vec_t'(1) << s;
        else if (s < 2 * LAMPS) return lamp_vec_t'(1) << (2 * LAMPS - 1 - s);
        else if (s == 2 * LAMPS) return '0;
        else                    return '1;
    endfunction

    // Shows 2 and 3: groups of width w move to the centre and back out.
    function automatic lamp_vec_t converge_frame(input int s, input int w);
        int half;
        int k;
        half = LAMPS / 2 - (w - 1);
        k    = (s < half) ? s : (2 * half - 2 - s);
        return mirror_group(k, w);
    endfunction

    // Show 4: three at each end, left half, right half, alternating.
    function automatic lamp_vec_t finale_frame(input int s);
        lamp_vec_t v;
        v = '0;
        case (s)
            0: v = mirror_group(0, 3);
            1: for (int i = LAMPS / 2; i < LAMPS; i++) v[i] = 1'b1;
            2: for (int i = 0; i < LAMPS / 2; i++) v[i] = 1'b1;
            default: for (int i = 0; i < LAMPS; i += 2) v[i] = 1'b1;
        endcase
        return v;
    endfunction

    // Value of frame s in show p.
    function automatic lamp_vec_t pattern_value(input int p, input int s);
        case (p)
            0:       return sweep_frame(s);
            1:       return converge_frame(s, 1);
            2:       return converge_frame(s, 2);
            default: return finale_frame(s);
        endcase
    endfunction

endpackage

// File: rtl/lamp_step_timer.sv
// Frame-time divider. Counts clock cycles and pulses tick_o on the last
// cycle of each frame. The frame length is (sel+1)*TICKS_PER_SEC. It is
// sampled from sel_i at reset and at each frame boundary only.
module lamp_step_timer #(
    parameter int TICKS_PER_SEC = 500,
    parameter int SEL_W         = 2,
    localparam int LEVELS       = 1 << SEL_W,
    localparam int CNT_W        = $clog2(TICKS_PER_SEC * LEVELS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] limit_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;

    // Frame length for a select value.
    function automatic logic [CNT_W-1:0] frame_cycles(input logic [SEL_W-1:0] s);
        return CNT_W'((int'(s) + 1) * TICKS_PER_SEC);
    endfunction

    // Last cycle of the current frame.
    always_comb tick_o = (cnt_q == (limit_q - CNT_W'(1)));

    // Count cycles; reload the count and latch the frame length at each boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            limit_q <= frame_cycles(sel_i);
        end else if (tick_o) begin
            cnt_q   <= '0;
            limit_q <= frame_cycles(sel_i);
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o   = cnt_q;
    assign limit_o = limit_q;

endmodule

// File: rtl/lamp_pattern_walker.sv
// Show and frame position tracker. On each tick it moves to the next frame.
// After the last frame of a show it moves to frame 0 of the next show, and
// wraps from the last show back to the first. Assumes len_i >= 1.
module lamp_pattern_walker
    import lamp_seq_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  step_idx_t len_i,
    output pat_idx_t  pat_o,
    output step_idx_t step_o,
    output logic      last_o
);

    pat_idx_t  pat_q;
    step_idx_t step_q;

    // Final frame of the current show.
    always_comb last_o = (step_q == (len_i - step_idx_t'(1)));

    // Advance the frame, and the show when the frame is the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pat_q  <= '0;
            step_q <= '0;
        end else if (tick_i) begin
            if (last_o) begin
                step_q <= '0;
                pat_q  <= (int'(pat_q) == NUM_PATTERNS - 1) ? '0 : pat_q + pat_idx_t'(1);
            end else begin
                step_q <= step_q + step_idx_t'(1);
            end
        end
    end

    assign pat_o  = pat_q;
    assign step_o = step_q;

endmodule

// File: rtl/lamp_pattern_rom.sv
// Frame value lookup. Builds one candidate frame value and length for each
// show and selects the one for the current show. Purely combinational.
module lamp_pattern_rom
    import lamp_seq_pkg::*;
(
    input  pat_idx_t  pat_i,
    input  step_idx_t step_i,
    output lamp_vec_t lamps_o,
    output step_idx_t len_o
);

    lamp_vec_t cand_val [NUM_PATTERNS];
    step_idx_t cand_len [NUM_PATTERNS];

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_show
        // Frame value and length of show p.
        always_comb begin
            cand_val[p] = pattern_value(p, int'(step_i));
            cand_len[p] = pattern_len(p);
        end
    end

    // Pick the current show.
    always_comb begin
        lamps_o = cand_val[pat_i];
        len_o   = cand_len[pat_i];
    end

endmodule

// File: rtl/lamp_sequencer.sv
// Top of the eight-lamp sequencer: a frame-time divider, a show/frame
// position tracker and a frame value table. Assumes a 500 Hz clock.
module lamp_sequencer
    import lamp_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 500,
    parameter int SEL_W         = 2,
    localparam int CNT_W        = $clog2(TICKS_PER_SEC * (1 << SEL_W) + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [SEL_W-1:0]    step_sel_i,
    output logic [LAMPS-1:0]    lamps_o
);

    logic             step_tick;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] tick_limit;
    pat_idx_t         pat_idx;
    step_idx_t        step_idx;
    step_idx_t        cur_len;
    logic             last_step;
    lamp_vec_t        frame_val;

    lamp_step_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SEL_W         (SEL_W)
    ) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (step_sel_i),
        .tick_o  (step_tick),
        .cnt_o   (tick_cnt),
        .limit_o (tick_limit)
    );

    lamp_pattern_walker i_walker (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (step_tick),
        .len_i  (cur_len),
        .pat_o  (pat_idx),
        .step_o (step_idx),
        .last_o (last_step)
    );

    lamp_pattern_rom i_rom (
        .pat_i   (pat_idx),
        .step_i  (step_idx),
        .lamps_o (frame_val),
        .len_o   (cur_len)
    );

    assign lamps_o = frame_val;

endmodule

// File: rtl/lamp_sequencer_chk.sv
// Assertion checker for lamp_sequencer, attached by bind below.
module lamp_sequencer_chk
    import lamp_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 500,
    parameter int SEL_W         = 2,
    localparam int CNT_W        = $clog2(TICKS_PER_SEC * (1 << SEL_W) + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [SEL_W-1:0] sel_i,
    input lamp_vec_t        lamps_i,
    input logic             tick_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] limit_i,
    input pat_idx_t         pat_i,
    input step_idx_t        step_i,
    input logic             last_i
);

    lamp_vec_t lamps_rev;
    always_comb for (int i = 0; i < LAMPS; i++) lamps_rev[i] = lamps_i[LAMPS - 1 - i];

    p_cnt_below_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i < limit_i);

    p_cnt_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> cnt_i == '0);

    p_limit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(limit_i));

    p_limit_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> int'(limit_i) == (int'($past(sel_i)) + 1) * TICKS_PER_SEC);

    p_single_lamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_i == 0 && int'(step_i) < 2 * LAMPS) |-> $countones(lamps_i) == 1);

    p_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_i == 1) |-> lamps_i == lamps_rev);

    p_mirror_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_i == 2) |-> lamps_i == lamps_rev);

    p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && last_i && int'(pat_i) == NUM_PATTERNS - 1) |=> (pat_i == '0 && step_i == '0));

    p_next_show_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && last_i && int'(pat_i) != NUM_PATTERNS - 1) |=> pat_i == $past(pat_i) + 1'b1);

    p_lamps_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(lamps_i));

endmodule

bind lamp_sequencer lamp_sequencer_chk #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SEL_W         (SEL_W)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (step_sel_i),
    .lamps_i (lamps_o),
    .tick_i  (step_tick),
    .cnt_i   (tick_cnt),
    .limit_i (tick_limit),
    .pat_i   (pat_idx),
    .step_i  (step_idx),
    .last_i  (last_step)
);

// File: tb/test_lamp_sequencer.sv
module test_lamp_sequencer;

    localparam int TPS    = 500;
    localparam int FRAMES = 34;
    localparam logic [7:0] EXP [FRAMES] = '{
        8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80,
        8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01,
        8'h00, 8'hFF,
        8'h81, 8'h42, 8'h24, 8'h18, 8'h24, 8'h42, 8'h81,
        8'hC3, 8'h66, 8'h3C, 8'h66, 8'hC3,
        8'hE7, 8'hF0, 8'h0F, 8'h55
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] lamps;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #5 clk = ~clk;

    lamp_sequencer i_lamp_sequencer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .step_sel_i (sel),
        .lamps_o    (lamps)
    );

    task automatic check(input logic [7:0] exp, input string req);
        n_tests++;
        if (lamps !== exp) begin
            n_fail++;
            $display("FAIL %s: lamps=%h expected=%h at %0t", req, lamps, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with the given select value; returns just after release at a negedge.
    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        sel   = s;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    function automatic string tag_of(input int i);
        if (i < 18) return "R4";
        if (i < 25) return "R5";
        if (i < 30) return "R6";
        return "R7";
    endfunction

    initial begin
        // R1: reset state
        wait_n(4);
        check(8'h01, "R1");
        rst_n = 1'b1;

        // Table walk at 1 s frames: whole cycle plus the wrap frame (R8)
        wait_n(TPS / 2);
        for (int i = 0; i <= FRAMES; i++) begin
            check(EXP[i % FRAMES], (i == FRAMES) ? "R8" : tag_of(i));
            wait_n(TPS);
        end

        // R2: frame length at each select value, probed at the boundary
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            wait_n((s + 1) * TPS - 1);
            check(8'h01, "R2");
            wait_n(1);
            check(8'h02, "R2");
        end

        // R3: raise select mid-frame; current frame keeps its length
        do_reset(2'd0);
        wait_n(200);
        sel = 2'd3;
        wait_n(299);
        check(8'h01, "R3");
        wait_n(1);
        check(8'h02, "R3");
        wait_n(4 * TPS - 1);
        check(8'h02, "R3");
        wait_n(1);
        check(8'h04, "R3");

        // R3: lower select mid-frame; the long frame still runs out
        sel = 2'd3;
        do_reset(2'd3);
        wait_n(100);
        sel = 2'd0;
        wait_n(4 * TPS - 101);
        check(8'h01, "R3");
        wait_n(1);
        check(8'h02, "R3");
        wait_n(TPS - 1);
        check(8'h02, "R3");
        wait_n(1);
        check(8'h04, "R3");

        // R1: reset in the middle of a show restarts show and divider
        wait_n(7 * TPS + 123);
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(1);
        check(8'h01, "R1");
        rst_n = 1'b1;
        wait_n(TPS - 1);
        check(8'h01, "R1");
        wait_n(1);
        check(8'h02, "R1");

        // R9: lamps hold between boundaries at a 2 s frame
        do_reset(2'd1);
        wait_n(2 * TPS);
        for (int k = 0; k < 2 * TPS - 1; k += 97) begin
            check(8'h02, "R9");
            wait_n(97);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule